// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register Block

This block holds the pin-control state for one bank of general-purpose pins, organised as four ports of eight pins each. For every port it keeps three writable 8-bit registers: a GPIO-select register that hands the pin to the general-purpose function, a drive-enable register and a drive-value register. A read-only register returns the pin level after a two-flop synchroniser. The register state is presented on flat 32-bit pin-side vectors, where pin p of port k sits at bit 8k+p.

Software reaches the registers over a small word-addressed bus with an address, a 16-bit write word, a write strobe and a combinational 8-bit read word. Each writable register appears twice. A plain write replaces all eight bits. A write to the alias copy, placed a fixed offset above the plain window, carries a per-bit mask in the upper byte, so single pins can be changed without a read-modify-write sequence. The bank size and the alias offset are parameters given in bytes.

Top module: `gpio_mw_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, every GPIO-select, drive-enable and drive-value bit is 0, so every pin is a non-GPIO input.
- R2: A plain write (strobe high) to word address 0+k (select), 4+k (drive enable) or 8+k (drive value), for port k in 0..3, loads write bits 7:0 into that port register at the clock edge. Bits 15:8 are ignored and other registers keep their values.
- R3: A read of a plain word address returns the current register value on read bits 7:0 in the same cycle. The pin vectors carry port k register bit p at bit 8k+p.
- R4: A write to alias word address 32+a, where a is one of the plain select, drive-enable or drive-value addresses, changes register bit b only when write bit 8+b is 1, and then loads write bit b. Bits whose mask bit is 0 keep their value.
- R5: A read of an alias word address returns the same value as a read of the matching plain address.
- R6: The input register at word address 12+k returns the pin levels of port k as they were two clock edges earlier. The same value appears on the synchronised pin output. Writes to 12+k change nothing.
- R7: Writes to unmapped addresses (16..31 and 44..63 by default, including the input group's alias slot) change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word address inside the bank |
| bus_wdata | input | 16 | Write word: mask in 15:8, value in 7:0 |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Combinational read word |
| pin_sel_o | output | 32 | GPIO-select per pin |
| pin_oe_o | output | 32 | Drive enable per pin |
| pin_out_o | output | 32 | Drive value per pin |
| pin_in_i | input | 32 | Asynchronous pin levels |
| pin_sync_o | output | 32 | Pin levels after the two-flop synchroniser |

## Verification
The assertions assume a synchronous reset and a bus whose address and write word are stable around each rising edge while the strobe is high. The synchroniser check also assumes that the pin inputs are sampled cleanly at clock edges. The bench changes every bus and pin input on the falling edge, half a cycle away from the sampling edge, so both assumptions hold. The pin inputs are held steady for several cycles around each capture, so that the two-edge latency can be observed exactly.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
   // register group, decoded from word address bits 3:2
   typedef enum logic [1:0] {
      GRP_SEL = 2'd0,
      GRP_OE  = 2'd1,
      GRP_OUT = 2'd2,
      GRP_IN  = 2'd3
   } grp_e;

   localparam int GROUP_WORDS = 4;   // words between register groups
   localparam int PLAIN_WORDS = 16;  // four groups of four ports
endpackage

// File: rtl/gpio_mw_dec.sv
module gpio_mw_dec
   import gpio_mw_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int PORTS      = 4,
   parameter int ALIAS_WORD = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              masked,
   output grp_e              grp,
   output logic [1:0]        port
);
   localparam logic [ADDR_W-1:0] ABASE = ADDR_W'(ALIAS_WORD);
   localparam logic [ADDR_W-1:0] AEND  = ADDR_W'(ALIAS_WORD + 3*GROUP_WORDS);
   localparam logic [ADDR_W-1:0] PEND  = ADDR_W'(PLAIN_WORDS);

   logic              in_alias, in_plain, port_ok;
   logic [ADDR_W-1:0] off;

   always_comb begin
      in_alias = (addr >= ABASE) && (addr < AEND);
      in_plain = (addr < PEND);
      off      = in_alias ? (addr - ABASE) : addr;
      port_ok  = ({1'b0, off[1:0]} < 3'(PORTS));
      hit      = (in_alias || in_plain) && port_ok;
      masked   = in_alias;
      grp      = grp_e'(off[3:2]);
      port     = off[1:0];
   end
endmodule

// File: rtl/gpio_mw_reg.sv
module gpio_mw_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic         masked,
   input  logic [W-1:0] wr_val,
   input  logic [W-1:0] wr_msk,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      if (masked) nxt = (q & ~wr_msk) | (wr_val & wr_msk);
      else        nxt = wr_val;
   end

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= nxt;
   end
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] s1;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1 <= '0;
         q  <= '0;
      end else begin
         s1 <= d;
         q  <= s1;
      end
   end
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
   import gpio_mw_pkg::*;
#(
   parameter int PIN_W       = 8,
   parameter int PORTS       = 4,
   parameter int BANK_STRIDE = 32'h100,
   parameter int ALIAS_OFS   = 32'h80,
   localparam int NPIN       = PIN_W * PORTS,
   localparam int ADDR_W     = $clog2(BANK_STRIDE / 4),
   localparam int ALIAS_WORD = ALIAS_OFS / 4,
   localparam int DATA_W     = 2 * PIN_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [PIN_W-1:0]  bus_rdata,
   output logic [NPIN-1:0]   pin_sel_o,
   output logic [NPIN-1:0]   pin_oe_o,
   output logic [NPIN-1:0]   pin_out_o,
   input  logic [NPIN-1:0]   pin_in_i,
   output logic [NPIN-1:0]   pin_sync_o
);
   // elaboration-time parameter checks
   if (PORTS < 1 || PORTS > GROUP_WORDS) begin : g_bad_ports
      $error("PORTS must be 1..4");
   end
   if (PIN_W < 1 || PIN_W > 8) begin : g_bad_pinw
      $error("PIN_W must be 1..8");
   end
   if (ALIAS_OFS % 4 != 0 || ALIAS_WORD < PLAIN_WORDS) begin : g_bad_alias
      $error("alias offset must be word aligned and above the plain window");
   end
   if (ALIAS_WORD + PLAIN_WORDS > BANK_STRIDE / 4) begin : g_bad_stride
      $error("alias window must fit inside the bank stride");
   end

   logic       hit, masked;
   grp_e       grp;
   logic [1:0] port;

   gpio_mw_dec #(
      .ADDR_W(ADDR_W), .PORTS(PORTS), .ALIAS_WORD(ALIAS_WORD)
   ) u_dec (
      .addr(bus_addr), .hit(hit), .masked(masked), .grp(grp), .port(port)
   );

   logic [NPIN-1:0] regs [3];

   for (genvar g = 0; g < 3; g++) begin : g_grp
      for (genvar k = 0; k < PORTS; k++) begin : g_port
         logic we;
         assign we = bus_we && hit && (grp == grp_e'(g)) && (port == 2'(k));
         gpio_mw_reg #(.W(PIN_W)) u_reg (
            .clk(clk), .rst(rst), .we(we), .masked(masked),
            .wr_val(bus_wdata[PIN_W-1:0]),
            .wr_msk(bus_wdata[DATA_W-1:PIN_W]),
            .q(regs[g][k*PIN_W +: PIN_W])
         );
      end
   end

   gpio_mw_sync #(.W(NPIN)) u_sync (
      .clk(clk), .rst(rst), .d(pin_in_i), .q(pin_sync_o)
   );

   assign pin_sel_o = regs[0];
   assign pin_oe_o  = regs[1];
   assign pin_out_o = regs[2];

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (grp)
            GRP_SEL: bus_rdata = regs[0][int'(port)*PIN_W +: PIN_W];
            GRP_OE:  bus_rdata = regs[1][int'(port)*PIN_W +: PIN_W];
            GRP_OUT: bus_rdata = regs[2][int'(port)*PIN_W +: PIN_W];
            default: bus_rdata = pin_sync_o[int'(port)*PIN_W +: PIN_W];
         endcase
      end
   end
endmodule

// File: rtl/gpio_mw_bank_chk.sv
module gpio_mw_bank_chk #(
   parameter int PIN_W      = 8,
   parameter int PORTS      = 4,
   parameter int ADDR_W     = 6,
   parameter int ALIAS_WORD = 32,
   localparam int NPIN      = PIN_W * PORTS,
   localparam int DATA_W    = 2 * PIN_W
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic [PIN_W-1:0]  bus_rdata,
   input logic [NPIN-1:0]   pin_sel_o,
   input logic [NPIN-1:0]   pin_oe_o,
   input logic [NPIN-1:0]   pin_out_o,
   input logic [NPIN-1:0]   pin_in_i,
   input logic [NPIN-1:0]   pin_sync_o
);
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (rst)           age <= '0;
      else if (age != 3) age <= age + 2'd1;
   end

   int  a_int;
   logic mapped;
   always_comb begin
      a_int  = int'(bus_addr);
      mapped = (a_int < 16 && (a_int % 4) < PORTS) ||
               (a_int >= ALIAS_WORD && a_int < ALIAS_WORD + 12 &&
                ((a_int - ALIAS_WORD) % 4) < PORTS);
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (pin_sel_o == '0 && pin_oe_o == '0 && pin_out_o == '0)); // R1

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !bus_we |=> ($stable(pin_sel_o) && $stable(pin_oe_o) && $stable(pin_out_o))); // R2

   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      !mapped |-> bus_rdata == '0); // R7

   AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
      (age >= 2) |-> pin_sync_o == $past(pin_in_i, 2)); // R6

   for (genvar k = 0; k < PORTS; k++) begin : g_msk
      AST_MASKED_DRIVE: assert property (@(posedge clk) disable iff (rst)
         (bus_we && a_int == ALIAS_WORD + 8 + k) |=>
         (((pin_out_o[k*PIN_W +: PIN_W] ^ $past(pin_out_o[k*PIN_W +: PIN_W]))
           & ~$past(bus_wdata[DATA_W-1:PIN_W])) == '0 &&
          ((pin_out_o[k*PIN_W +: PIN_W] ^ $past(bus_wdata[PIN_W-1:0]))
           & $past(bus_wdata[DATA_W-1:PIN_W])) == '0)); // R4
   end
endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(
   .PIN_W(PIN_W), .PORTS(PORTS), .ADDR_W(ADDR_W), .ALIAS_WORD(ALIAS_WORD)
) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_sel_o(pin_sel_o),
   .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o), .pin_in_i(pin_in_i),
   .pin_sync_o(pin_sync_o)
);

// File: tb/gpio_mw_bank_test.sv
module gpio_mw_bank_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        rst;
   logic [5:0]  addr;
   logic [15:0] wdata;
   logic        we;
   logic [31:0] pin_in;
   wire  [7:0]  rdata;
   wire  [31:0] sel, oe, out, syn;

   gpio_mw_bank uut (
      .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
      .bus_rdata(rdata), .pin_sel_o(sel), .pin_oe_o(oe), .pin_out_o(out),
      .pin_in_i(pin_in), .pin_sync_o(syn)
   );

   int checks = 0;
   int fails  = 0;
   logic [7:0] m [3][4];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      addr = 6'(a); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input int a, input string req, input logic [7:0] exp);
      @(negedge clk);
      addr = 6'(a);
      #1 chk(req, {24'b0, rdata}, {24'b0, exp});
   endtask

   function automatic logic [31:0] vec(input int g);
      return {m[g][3], m[g][2], m[g][1], m[g][0]};
   endfunction

   task automatic check_all(input string req);
      for (int g = 0; g < 3; g++)
         for (int k = 0; k < 4; k++) rd(g*4 + k, req, m[g][k]);
      chk({req, " sel pins"}, sel, vec(0));
      chk({req, " oe pins"},  oe,  vec(1));
      chk({req, " out pins"}, out, vec(2));
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] masks [6];
      masks = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5, 8'h3C};
      rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; pin_in = '0;
      for (int g = 0; g < 3; g++) for (int k = 0; k < 4; k++) m[g][k] = '0;
      repeat (3) @(negedge clk);
      chk("R1 sel in reset", sel, 32'h0);
      chk("R1 oe in reset",  oe,  32'h0);
      chk("R1 out in reset", out, 32'h0);
      rst = 1'b0;
      check_all("R1 after reset");

      // R2/R3: plain writes, upper byte must be ignored
      for (int g = 0; g < 3; g++)
         for (int k = 0; k < 4; k++) begin
            logic [7:0] d;
            d = 8'((g*4 + k) * 37 + 3);
            wr(g*4 + k, {8'(k*29 + 1), d});
            m[g][k] = d;
            check_all("R2 R3 plain write");
         end

      // R4/R5: masked writes through the alias window
      for (int g = 0; g < 3; g++)
         for (int k = 0; k < 4; k++)
            for (int i = 0; i < 6; i++) begin
               logic [7:0] v;
               v = ~m[g][k] ^ 8'(i * 19);
               wr(32 + g*4 + k, {masks[i], v});
               m[g][k] = (m[g][k] & ~masks[i]) | (v & masks[i]);
               rd(g*4 + k, "R4 masked write", m[g][k]);
               rd(32 + g*4 + k, "R5 alias read", m[g][k]);
            end
      check_all("R4 masked write pins");

      // R6: two-edge synchroniser latency, input register read-only
      for (int t = 0; t < 4; t++) begin
         logic [31:0] v, prev;
         prev = pin_in;
         v = 32'h9E37_79B9 * (t + 1);
         @(negedge clk);
         pin_in = v; addr = 6'(12 + t);
         @(posedge clk); #1;
         chk("R6 not yet after one edge", {24'b0, rdata}, {24'b0, prev[t*8 +: 8]});
         @(posedge clk); #1;
         chk("R6 read after two edges", {24'b0, rdata}, {24'b0, v[t*8 +: 8]});
         chk("R6 sync pins", syn, v);
         wr(12 + t, 16'hFFFF ^ 16'(t));
         rd(12 + t, "R6 input write ignored", v[t*8 +: 8]);
      end
      check_all("R6 regs after input writes");

      // R7: unmapped addresses
      for (int a = 0; a < 64; a++) begin
         if ((a >= 16 && a < 32) || a >= 44) begin
            wr(a, 16'hFFFF);
            rd(a, "R7 unmapped read", 8'h00);
         end
      end
      check_all("R7 regs after unmapped writes");

      finish_run();
   end
endmodule